// File: doc/BRIEF.md
# Oscillator Trim Loop Against a Reference Clock

This block keeps a local oscillator near its target rate by timing it against a slower, stable reference clock. A counter on the reference clock sets the length of each measurement window. A free-running counter on the local clock counts how many local cycles fit into that window. At the end of each window the local count is compared with an expected value and a tolerance band. A signed trim code is then moved one step toward the target, and a one-cycle flag reports the direction of the step. The trim code is meant to drive the analog tuning input of the oscillator, which is outside this block.

The expected count is the local frequency multiplied by the window time. For a nominal 8 MHz oscillator and a window of `win_len` reference periods, that is 8e6 × `win_len` / f_ref. The integrator computes this value and applies it on `exp_cnt`. The end of each window is raised in the reference domain as a level toggle. A two-flop synchronizer carries it into the local domain, and an edge detector there turns it into a single-cycle event.

Top module: `osc_trim_ctrl`

## Requirements
- R1: While `rst_n` is low, `trim` is 0, `too_fast` and `too_slow` are 0, and both counters are cleared.
- R2: The reference counter ends a window every `win_len` reference cycles (`win_len` ≥ 1). It restarts from zero at each window end.
- R3: The measured count is the number of local clock cycles between two consecutive window-end events. The first window end after reset only starts a measurement and never changes `trim`.
- R4: If the measured count is greater than `exp_cnt + tol`, `trim` is decremented by one and `too_fast` is high for exactly one local cycle.
- R5: If `tol < exp_cnt` and the measured count is less than `exp_cnt - tol`, `trim` is incremented by one and `too_slow` is high for one local cycle. If `tol ≥ exp_cnt`, no slow decision is made.
- R6: If the measured count lies in the inclusive band [`exp_cnt - tol`, `exp_cnt + tol`], `trim` holds and neither flag pulses. `trim` never changes unless a flag pulses.
- R7: `trim` is 6-bit two's complement and saturates at -32 (bit pattern 100000) and +31 (011111). At a limit it holds, but the matching flag still pulses.
- R8: When a reference rising edge ends a window, the resulting `trim` and flag values appear after the third local rising edge that follows it.
- R9: `too_fast` and `too_slow` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, the oscillator being trimmed |
| rst_n | input | 1 | Active-low asynchronous reset, applied to both domains |
| ref_clk | input | 1 | Stable reference clock |
| win_len | input | REF_W (16) | Window length in reference cycles |
| exp_cnt | input | LOC_W (20) | Expected local cycles per window |
| tol | input | LOC_W (20) | Allowed deviation from `exp_cnt` |
| trim | output | TRIM_W (6) | Signed trim code |
| too_fast | output | 1 | One-cycle pulse when a decrement decision is made |
| too_slow | output | 1 | One-cycle pulse when an increment decision is made |

## Verification
Two things can happen in the same local cycle: the window-end event that samples and clears the local counter, and a step decision taken while `trim` already sits at a saturation limit. The bench provokes this case by setting `exp_cnt` far from the true count for enough windows that the code reaches -32, and later +31. It then keeps the same setting for further windows. A behavioural model runs in the bench. It counts reference windows, delays each window end by three local edges and applies the band and limit rules. On every local cycle the model is compared with the outputs, so a window end at a limit must give a flag pulse with an unchanged code. The same model also judges the band edges, where the count equals `exp_cnt ± tol`.

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter int REF_W       = 16,
  parameter int LOC_W       = 20,
  parameter int TRIM_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_clk,
  input  logic [REF_W-1:0]         win_len,
  input  logic [LOC_W-1:0]         exp_cnt,
  input  logic [LOC_W-1:0]         tol,
  output logic signed [TRIM_W-1:0] trim,
  output logic                     too_fast,
  output logic                     too_slow
);
  localparam logic signed [TRIM_W-1:0] TRIM_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic signed [TRIM_W-1:0] TRIM_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic signed [TRIM_W-1:0] STEP     = TRIM_W'(1);
  localparam logic [LOC_W-1:0]         LOC_TOP  = '1;

  logic [REF_W-1:0] ref_cnt;
  logic             ref_tog;
  logic             ref_end;

  assign ref_end = ({1'b0, ref_cnt} + (REF_W+1)'(1)) >= {1'b0, win_len};

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      ref_tog <= 1'b0;
    end else if (ref_end) begin
      ref_cnt <= '0;
      ref_tog <= ~ref_tog;
    end else begin
      ref_cnt <= ref_cnt + REF_W'(1);
    end
  end

  logic [SYNC_STAGES:0] sync_q;
  logic                 evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ref_tog};
  end

  assign evt = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  logic [LOC_W-1:0] loc_cnt;
  logic             primed;
  logic [LOC_W:0]   meas, band_hi, band_lo;
  logic             over, under;

  assign meas    = {1'b0, loc_cnt} + (LOC_W+1)'(1);
  assign band_hi = {1'b0, exp_cnt} + {1'b0, tol};
  assign band_lo = {1'b0, exp_cnt} - {1'b0, tol};
  assign over    = meas > band_hi;
  assign under   = (tol < exp_cnt) && (meas < band_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_cnt  <= '0;
      primed   <= 1'b0;
      trim     <= '0;
      too_fast <= 1'b0;
      too_slow <= 1'b0;
    end else begin
      too_fast <= 1'b0;
      too_slow <= 1'b0;
      if (evt) begin
        loc_cnt <= '0;
        primed  <= 1'b1;
        if (primed && over) begin
          too_fast <= 1'b1;
          if (trim != TRIM_MIN) trim <= trim - STEP;
        end else if (primed && under) begin
          too_slow <= 1'b1;
          if (trim != TRIM_MAX) trim <= trim + STEP;
        end
      end else if (loc_cnt != LOC_TOP) begin
        loc_cnt <= loc_cnt + LOC_W'(1);
      end
    end
  end
endmodule

module osc_trim_chk #(
  parameter int TRIM_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic signed [TRIM_W-1:0] trim,
  input logic                     too_fast,
  input logic                     too_slow
);
  localparam logic signed [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic signed [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};

  always @(posedge clk)
    if (!rst_n) a_r1_reset_state: assert (trim == '0 && !too_fast && !too_slow);

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(too_fast && too_slow));

  a_r4_fast_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (too_fast && $past(trim) != T_MIN) |-> trim == $past(trim) - TRIM_W'(1));

  a_r5_slow_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
    (too_slow && $past(trim) != T_MAX) |-> trim == $past(trim) + TRIM_W'(1));

  a_r6_hold_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!too_fast && !too_slow) |-> $stable(trim));

  a_r7_floor_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (too_fast && $past(trim) == T_MIN) |-> trim == T_MIN);

  a_r7_ceiling_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (too_slow && $past(trim) == T_MAX) |-> trim == T_MAX);

  a_r4_fast_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    too_fast |=> !too_fast);
endmodule

bind osc_trim_ctrl osc_trim_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trim(trim), .too_fast(too_fast), .too_slow(too_slow)
);

// File: tb/tb_osc_trim_ctrl.sv
`timescale 1ns/1ps
module tb_osc_trim_ctrl;
  logic               clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic [15:0]        win_len = 16'd4;
  logic [19:0]        exp_cnt = 20'd40, tol = 20'd0;
  logic signed [5:0]  trim;
  logic               too_fast, too_slow;

  osc_trim_ctrl dut (.clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .win_len(win_len),
    .exp_cnt(exp_cnt), .tol(tol), .trim(trim), .too_fast(too_fast), .too_slow(too_slow));

  always #10 clk = ~clk;
  initial begin #5; forever #100 ref_clk = ~ref_clk; end

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model
  int rc = 0;
  int q[$];
  int since = 0, m_trim = 0;
  bit m_primed = 0, m_fast = 0, m_slow = 0;

  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rc = 0;
    else if (rc + 1 >= int'(win_len)) begin rc = 0; q.push_back(3); end
    else rc = rc + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      since = 0; m_trim = 0; m_primed = 0; m_fast = 0; m_slow = 0; q.delete();
    end else begin
      m_fast = 0; m_slow = 0;
      since = since + 1;
      for (int i = 0; i < q.size(); i++) q[i] = q[i] - 1;
      if (q.size() > 0 && q[0] == 0) begin
        void'(q.pop_front());
        if (m_primed) begin
          if (since > int'(exp_cnt) + int'(tol)) begin
            m_fast = 1; if (m_trim > -32) m_trim = m_trim - 1;
          end else if (int'(tol) < int'(exp_cnt) && since < int'(exp_cnt) - int'(tol)) begin
            m_slow = 1; if (m_trim < 31) m_trim = m_trim + 1;
          end
        end
        m_primed = 1;
        since = 0;
      end
    end
  end

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check("trim R3/R4/R5/R6/R7/R8", int'(trim), m_trim);
    check("too_fast R2/R4/R8", int'(too_fast), int'(m_fast));
    check("too_slow R2/R5/R8", int'(too_slow), int'(m_slow));
    check("flags exclusive R9", int'(too_fast && too_slow), 0);
  end

  task automatic run(int n); repeat (n) @(negedge clk); endtask

  initial begin
    #202 rst_n = 1'b1;
    @(negedge clk);
    run(2);
    check("R1 trim after reset", int'(trim), 0);
    run(300);
    check("R6 exact match holds", int'(trim), 0);
    exp_cnt = 30; tol = 2;
    run(1500);
    check("R7 floor -32", int'(trim), -32);
    exp_cnt = 38; tol = 2;
    run(200);
    check("R6 upper band edge", int'(trim), -32);
    exp_cnt = 50; tol = 3;
    run(2900);
    check("R7 ceiling +31", int'(trim), 31);
    exp_cnt = 42; tol = 2;
    run(200);
    check("R6 lower band edge", int'(trim), 31);
    exp_cnt = 45; tol = 100;
    run(200);
    check("R5 wide tol no slow", int'(trim), 31);
    exp_cnt = 37; tol = 2;
    run(130);
    check("R4 stepping down", int'(trim), m_trim);
    win_len = 2; exp_cnt = 20; tol = 0;
    run(400);
    check("R2 short window", int'(trim), m_trim);
    exp_cnt = 25;
    run(200);
    check("R5 short window slow", int'(trim), m_trim);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    done = 1; checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule